// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs one integer vector instruction at a time against a small internal file of vector registers. After an instruction is accepted on the issue handshake, the sequencer walks the element positions one per clock, from element 0 up to the active vector length. At each position it reads the two source elements, combines them in an integer unit and writes the destination element. The second operand is either a second vector register or a scalar that is broadcast to every position.

A compare instruction writes nothing to the register file. Instead it builds a per-element condition mask. Any later instruction can set its masked bit so that positions whose mask bit is clear keep their old destination value. The vector length comes from a programmable length register, whose writes saturate at the maximum length. A load port and a combinational read port stand in for the memory path: they fill and inspect register contents between instructions.

Top module: `vseq_top`

## Requirements
- R1: After reset, iss_ready is 1, done is 0, the vector length is 64 and every mask bit is 1. A masked instruction issued before any compare therefore writes all 64 elements.
- R2: With iss_sform=0, destination element i becomes A[i] op B[i] modulo 2^DW. The iss_op codes are 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 XOR, and 6 or 7 copy A.
- R3: With iss_sform=1, the scalar on iss_scalar, sampled in the acceptance cycle, replaces B[i] at every element position.
- R4: Only elements 0 to L-1 are written, where L is the vector length in effect at acceptance. Elements at L and above keep their values.
- R5: A length write (vlr_we=1) stores vlr_in, except that any value above 64 is stored as 64.
- R6: iss_op code 5 is a compare. For i below L it sets mask bit i to 1 when signed A[i] is less than the signed second operand (B[i] or the scalar), and to 0 otherwise. Mask bits at L and above are unchanged. It writes no vector register, and its masked bit has no effect.
- R7: With iss_masked=1, an element whose mask bit is 0 keeps its old destination value. With iss_masked=0, all elements below L are written.
- R8: For L≥1, iss_ready is low for exactly L cycles after the acceptance edge. done is high for the single cycle that follows the last element write, and iss_ready returns high in that same cycle.
- R9: With L=0, done is high in the cycle after acceptance, iss_ready stays high, and no register changes.
- R10: A length write made while an instruction runs does not change that instruction's element count. It does apply to the next instruction.
- R11: A load-port write (ld_en=1) stores ld_data at ld_reg/ld_idx when no instruction is running, and is ignored while one runs. rd_data shows register rd_reg, element rd_idx, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Sequencer idle; offer is taken when both are high |
| iss_op | input | 3 | Operation code |
| iss_sform | input | 1 | 1 = second operand is the scalar |
| iss_masked | input | 1 | 1 = writes gated by mask |
| iss_vd | input | 3 | Destination register |
| iss_va | input | 3 | First source register |
| iss_vb | input | 3 | Second source register |
| iss_scalar | input | DW | Scalar operand |
| vlr_we | input | 1 | Vector length write strobe |
| vlr_in | input | 7 | New vector length |
| ld_en | input | 1 | Load-port element write |
| ld_reg | input | 3 | Load-port register |
| ld_idx | input | 6 | Load-port element index |
| ld_data | input | DW | Load-port data |
| rd_reg | input | 3 | Read-port register |
| rd_idx | input | 6 | Read-port element index |
| rd_data | output | DW | Read-port data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a masked instruction whose mask holds a mix of bits. Some of those bits were set by a compare over a shorter length, and some were left at their reset value of one above that length. The stimulus sets a short length and runs a compare against a chosen scalar on random data. It then raises the length and issues masked arithmetic. Only a correct mask model predicts which destination elements survive. Length and load writes are also injected while an instruction is in flight, and random instruction streams reuse source and destination registers so that aliasing occurs.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SLT = 3'd5,
        OP_CPA = 3'd6,
        OP_CPB = 3'd7
    } vop_e;
endpackage

// File: rtl/vseq_alu.sv
module vseq_alu
    import vseq_pkg::*;
#(
    parameter int DW = 16
) (
    input  vop_e          op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic          lt
);
    always_comb begin
        lt = $signed(opa) < $signed(opb);
        case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            default: res = opa;
        endcase
    end
endmodule

// File: rtl/vseq_vrf.sv
module vseq_vrf #(
    parameter int NREG = 8,
    parameter int MVL  = 64,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic [$clog2(NREG)-1:0] ra_reg,
    input  logic [$clog2(MVL)-1:0]  ra_idx,
    output logic [DW-1:0]           ra_data,
    input  logic [$clog2(NREG)-1:0] rb_reg,
    input  logic [$clog2(MVL)-1:0]  rb_idx,
    output logic [DW-1:0]           rb_data,
    input  logic [$clog2(NREG)-1:0] rx_reg,
    input  logic [$clog2(MVL)-1:0]  rx_idx,
    output logic [DW-1:0]           rx_data,
    input  logic                    ew_en,
    input  logic [$clog2(NREG)-1:0] ew_reg,
    input  logic [$clog2(MVL)-1:0]  ew_idx,
    input  logic [DW-1:0]           ew_data,
    input  logic                    lw_en,
    input  logic [$clog2(NREG)-1:0] lw_reg,
    input  logic [$clog2(MVL)-1:0]  lw_idx,
    input  logic [DW-1:0]           lw_data
);
    localparam int DEPTH = NREG * MVL;
    localparam int AW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] flat(input int r, input int i);
        return AW'(r * MVL + i);
    endfunction

    assign ra_data = mem[flat(int'(ra_reg), int'(ra_idx))];
    assign rb_data = mem[flat(int'(rb_reg), int'(rb_idx))];
    assign rx_data = mem[flat(int'(rx_reg), int'(rx_idx))];

    always_ff @(posedge clk) begin
        if (ew_en)
            mem[flat(int'(ew_reg), int'(ew_idx))] <= ew_data;
        else if (lw_en)
            mem[flat(int'(lw_reg), int'(lw_idx))] <= lw_data;
    end

    AST_ONE_WRITER: assert property (@(posedge clk) !(ew_en && lw_en)); // R11
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int NREG = 8,
    parameter int MVL  = 64,
    parameter int DW   = 16,
    localparam int RW  = $clog2(NREG),
    localparam int IW  = $clog2(MVL),
    localparam int LW  = $clog2(MVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [2:0]    iss_op,
    input  logic          iss_sform,
    input  logic          iss_masked,
    input  logic [RW-1:0] iss_vd,
    input  logic [RW-1:0] iss_va,
    input  logic [RW-1:0] iss_vb,
    input  logic [DW-1:0] iss_scalar,
    input  logic          vlr_we,
    input  logic [LW-1:0] vlr_in,
    input  logic          cmp_bit,
    output logic          iss_ready,
    output logic          done,
    output logic          busy,
    output logic [IW-1:0] idx,
    output vop_e          op,
    output logic          sform,
    output logic [RW-1:0] vd,
    output logic [RW-1:0] va,
    output logic [RW-1:0] vb,
    output logic [DW-1:0] scal,
    output logic          el_we
);
    typedef struct packed {
        logic           busy;
        logic           done;
        logic [LW-1:0]  vlr;
        logic [LW-1:0]  len;
        logic [IW-1:0]  idx;
        logic [MVL-1:0] mask;
        vop_e           op;
        logic           sform;
        logic           masked;
        logic [RW-1:0]  vd;
        logic [RW-1:0]  va;
        logic [RW-1:0]  vb;
        logic [DW-1:0]  scal;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic last;

    assign accept = iss_valid && !st_q.busy;
    assign last   = ({1'b0, st_q.idx} == st_q.len - LW'(1));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (vlr_we)
            st_d.vlr = (vlr_in > LW'(MVL)) ? LW'(MVL) : vlr_in;
        if (accept) begin
            st_d.op     = vop_e'(iss_op);
            st_d.sform  = iss_sform;
            st_d.masked = iss_masked;
            st_d.vd     = iss_vd;
            st_d.va     = iss_va;
            st_d.vb     = iss_vb;
            st_d.scal   = iss_scalar;
            st_d.len    = st_q.vlr;
            st_d.idx    = '0;
            st_d.busy   = (st_q.vlr != '0);
            st_d.done   = (st_q.vlr == '0);
        end else if (st_q.busy) begin
            if (st_q.op == OP_SLT)
                st_d.mask[st_q.idx] = cmp_bit;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.vlr  <= LW'(MVL);
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_ready = !st_q.busy;
    assign done      = st_q.done;
    assign busy      = st_q.busy;
    assign idx       = st_q.idx;
    assign op        = st_q.op;
    assign sform     = st_q.sform;
    assign vd        = st_q.vd;
    assign va        = st_q.va;
    assign vb        = st_q.vb;
    assign scal      = st_q.scal;
    assign el_we     = st_q.busy && (st_q.op != OP_SLT) &&
                       (!st_q.masked || st_q.mask[st_q.idx]);

    AST_VLR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vlr <= LW'(MVL)); // R5
    AST_IDX_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, st_q.idx} < st_q.len)); // R4
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !last |=> $stable(st_q.len) && st_q.busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !accept |=> !done); // R8
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        accept && st_q.vlr == '0 |=> done && iss_ready); // R9
    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.op != OP_SLT |=> $stable(st_q.mask)); // R7
endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
#(
    parameter int NREG = 8,
    parameter int MVL  = 64,
    parameter int DW   = 16,
    localparam int RW  = $clog2(NREG),
    localparam int IW  = $clog2(MVL),
    localparam int LW  = $clog2(MVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    output logic          iss_ready,
    input  logic [2:0]    iss_op,
    input  logic          iss_sform,
    input  logic          iss_masked,
    input  logic [RW-1:0] iss_vd,
    input  logic [RW-1:0] iss_va,
    input  logic [RW-1:0] iss_vb,
    input  logic [DW-1:0] iss_scalar,
    input  logic          vlr_we,
    input  logic [LW-1:0] vlr_in,
    input  logic          ld_en,
    input  logic [RW-1:0] ld_reg,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [RW-1:0] rd_reg,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    logic          busy, sform, el_we, lt;
    logic [IW-1:0] idx;
    vop_e          op;
    logic [RW-1:0] vd, va, vb;
    logic [DW-1:0] scal, a_data, b_data, res;

    vseq_ctrl #(.NREG(NREG), .MVL(MVL), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_sform(iss_sform), .iss_masked(iss_masked), .iss_vd(iss_vd),
        .iss_va(iss_va), .iss_vb(iss_vb), .iss_scalar(iss_scalar),
        .vlr_we(vlr_we), .vlr_in(vlr_in), .cmp_bit(lt),
        .iss_ready(iss_ready), .done(done), .busy(busy), .idx(idx),
        .op(op), .sform(sform), .vd(vd), .va(va), .vb(vb), .scal(scal),
        .el_we(el_we)
    );

    vseq_vrf #(.NREG(NREG), .MVL(MVL), .DW(DW)) u_vrf (
        .clk(clk),
        .ra_reg(va), .ra_idx(idx), .ra_data(a_data),
        .rb_reg(vb), .rb_idx(idx), .rb_data(b_data),
        .rx_reg(rd_reg), .rx_idx(rd_idx), .rx_data(rd_data),
        .ew_en(el_we), .ew_reg(vd), .ew_idx(idx), .ew_data(res),
        .lw_en(ld_en && !busy), .lw_reg(ld_reg), .lw_idx(ld_idx),
        .lw_data(ld_data)
    );

    vseq_alu #(.DW(DW)) u_alu (
        .op(op), .opa(a_data), .opb(sform ? scal : b_data),
        .res(res), .lt(lt)
    );
endmodule

// File: tb/vseq_top_test.sv
module vseq_top_test;
    localparam int NREG = 8;
    localparam int MVL  = 64;
    localparam int DW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 0, iss_sform = 0, iss_masked = 0, vlr_we = 0, ld_en = 0;
    logic [2:0] iss_op = 0, iss_vd = 0, iss_va = 0, iss_vb = 0, ld_reg = 0, rd_reg = 0;
    logic [DW-1:0] iss_scalar = 0, ld_data = 0;
    logic [6:0] vlr_in = 0;
    logic [5:0] ld_idx = 0, rd_idx = 0;
    logic iss_ready, done;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] m [NREG][MVL];
    logic [MVL-1:0] mmask = '1;
    int mvlr = 64;

    always #2.5 clk = ~clk;

    vseq_top uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_sform(iss_sform), .iss_masked(iss_masked),
        .iss_vd(iss_vd), .iss_va(iss_va), .iss_vb(iss_vb), .iss_scalar(iss_scalar),
        .vlr_we(vlr_we), .vlr_in(vlr_in), .ld_en(ld_en), .ld_reg(ld_reg),
        .ld_idx(ld_idx), .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done)
    );

    function automatic logic [DW-1:0] f_op(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return a;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_reg(int r);
        for (int i = 0; i < MVL; i++) begin
            @(negedge clk);
            ld_en = 1; ld_reg = 3'(r); ld_idx = 6'(i); ld_data = DW'($urandom);
            m[r][i] = ld_data;
            @(posedge clk);
        end
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic set_vlr(int v);
        @(negedge clk);
        vlr_we = 1; vlr_in = 7'(v);
        @(posedge clk);
        @(negedge clk);
        vlr_we = 0;
        mvlr = (v > MVL) ? MVL : v;
    endtask

    task automatic check_regs(string req);
        for (int r = 0; r < NREG; r++) begin
            int bad = 0;
            int act = 0;
            int exp = 0;
            for (int i = 0; i < MVL; i++) begin
                rd_reg = 3'(r); rd_idx = 6'(i);
                #0.1;
                if (rd_data !== m[r][i] && bad == 0) begin
                    bad = 1; act = int'(rd_data); exp = int'(m[r][i]);
                end
            end
            chk(bad == 0, req, act, exp);
        end
    endtask

    task automatic run(int op, bit sf, bit mk, int vd, int va, int vb,
                       logic [DW-1:0] sc, bit poke, string req);
        int n = mvlr;
        int cnt = 0;
        int pv = 1 + int'($urandom_range(0, 70));
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] a = m[va][i];
            logic [DW-1:0] b = sf ? sc : m[vb][i];
            if (op == 5) mmask[i] = ($signed(a) < $signed(b));
            else if (!mk || mmask[i]) m[vd][i] = f_op(op, a, b);
        end
        @(negedge clk);
        iss_valid = 1; iss_op = 3'(op); iss_sform = sf; iss_masked = mk;
        iss_vd = 3'(vd); iss_va = 3'(va); iss_vb = 3'(vb); iss_scalar = sc;
        @(posedge clk);
        @(negedge clk);
        iss_valid = 0;
        iss_scalar = ~sc;
        while (1) begin
            if (iss_ready) break;
            if (cnt == 0 && poke) begin
                vlr_we = 1; vlr_in = 7'(pv);
                ld_en = 1; ld_reg = 3'(vd); ld_idx = 0; ld_data = ~m[vd][0];
            end else begin
                vlr_we = 0; ld_en = 0;
            end
            cnt++;
            if (cnt > MVL + 4) break;
            @(posedge clk);
            @(negedge clk);
        end
        vlr_we = 0; ld_en = 0;
        if (poke && n > 0) mvlr = (pv > MVL) ? MVL : pv;
        chk(cnt == n, {req, " R8 ready-low cycles"}, cnt, n);
        chk(done == 1'b1, {req, " R8 done pulse"}, int'(done), 1);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, {req, " R8 done one cycle"}, int'(done), 0);
        check_regs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        chk(iss_ready == 1'b1, "R1 ready in reset", int'(iss_ready), 1);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int r = 0; r < NREG; r++) load_reg(r);
        check_regs("R11 load and read");
        // R1 R7: masked op before any compare writes all 64 elements
        run(4, 0, 1, 5, 2, 3, 0, 0, "R1 R7 reset mask");
        // R2 each vector-vector op
        for (int op = 0; op < 5; op++) run(op, 0, 0, 6, 0, 1, 0, 0, "R2 vv op");
        // R3 vector-scalar
        run(0, 1, 0, 7, 1, 2, 16'h1234, 0, "R3 vs add");
        run(1, 1, 0, 4, 3, 0, 16'h8001, 0, "R3 vs sub");
        // R5 clamp, R4 short length
        set_vlr(100);
        run(3, 0, 0, 2, 1, 0, 0, 0, "R5 clamp to 64");
        set_vlr(10);
        run(1, 0, 0, 3, 4, 5, 0, 0, "R4 length 10");
        // R6 compare at length 20, then masked op at 40 (R7)
        set_vlr(20);
        run(5, 1, 1, 0, 6, 0, 16'h0000, 0, "R6 compare");
        set_vlr(40);
        run(0, 1, 1, 1, 2, 0, 16'h0101, 0, "R7 masked");
        run(5, 0, 0, 0, 3, 4, 0, 0, "R6 vv compare");
        run(2, 0, 1, 7, 3, 4, 0, 0, "R7 masked vv");
        // R9 zero length
        set_vlr(0);
        run(0, 0, 0, 2, 0, 1, 0, 0, "R9 zero length");
        // R4 boundary lengths
        set_vlr(1);
        run(4, 1, 0, 5, 5, 0, 16'hffff, 0, "R4 length 1");
        set_vlr(64);
        run(0, 0, 0, 6, 6, 6, 0, 0, "R4 length 64 alias");
        // R10 R11 writes during execution
        run(1, 0, 0, 3, 1, 2, 0, 1, "R10 R11 mid-run writes");
        run(0, 0, 0, 4, 4, 5, 0, 0, "R10 next uses new length");
        // random stream
        for (int k = 0; k < 30; k++) begin
            int op = int'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) set_vlr(int'($urandom_range(0, 80)));
            if ($urandom_range(0, 5) == 0) load_reg(int'($urandom_range(0, 7)));
            run(op, 1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                DW'($urandom), 1'($urandom_range(0, 4) == 0), "R2 R3 R7 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule